// File: doc/BRIEF.md
# Boot-Override Cartridge Bus Enable

This block drives the active-low enable of the buffer that joins a cartridge ROM to the host data bus. The ROM's own chip and output selects are tied active. As a result, the only thing that decides whether the ROM reaches the bus is this enable. The block has two modes, held in a single sticky state bit.

After power-on reset the block is in override mode. In this mode the ROM answers every processor read at any address, so the host CPU takes its reset vector and first instructions from the cartridge. During writes the buffer stays off, so the host's writes to its own control port are not overpowered.

The block watches the host's gated top address line. This line is the top address bit combined with the boot ROM's active-low select, and it stays low while the boot ROM is mapped. Once that line goes high, the block enters normal mode and stays there until the next power-on reset. In normal mode the ROM is enabled for top-half addresses only. The switch takes effect in the same cycle that the line rises. The stored bit updates on the next clock edge.

Top module: `bootovr_bus_enable`

## Requirements
- R1: While `rst` is high the block is in override mode, and the first cycle after reset is released is also in override mode, whatever `a15_gated` did during reset.
- R2: In override mode, `buf_en_n` is 0 whenever `phi2` = 1 and `rw` = 1 (processor read), regardless of address.
- R3: In override mode, `buf_en_n` is 1 whenever `phi2` = 0 or `rw` = 0 (no read, including write cycles).
- R4: Outside reset, `a15_gated` = 1 selects normal mode in the same cycle. The mode stays normal after `a15_gated` falls, until `rst`.
- R5: In normal mode, `buf_en_n` = 0 exactly when `a15_gated` = 1, independent of `phi2` and `rw`.
- R6: `rst` takes priority over `a15_gated`. With both high, the output follows the override rule (so a write gives `buf_en_n` = 1), and the stored mode returns to override.
- R7: The enable is active low: 0 lets the ROM drive the bus, 1 isolates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the mode bit |
| rst | input | 1 | Synchronous active-high power-on reset |
| phi2 | input | 1 | Host bus phase-2 clock level |
| rw | input | 1 | Host read/write strobe, 1 = read |
| a15_gated | input | 1 | Top address bit ANDed with boot ROM select |
| buf_en_n | output | 1 | Active-low bus buffer enable |

## Verification
The bench plays a host boot sequence. First come reset and reads in override mode. Next, writes and idle phases show that override mode only answers reads. Then the gated address line rises, and reads and writes follow with the address both high and low. These show that normal mode ignores the strobes, and that the mode stays set after the line falls. Reset is then applied with the address line high, during both a read and a write. This separates reset priority from a mode switch. A single one-cycle pulse on the address line during an idle phase checks that the mode is latched by a short event.

// File: rtl/bootovr_pkg.sv
package bootovr_pkg;

    typedef enum logic {
        MODE_OVERRIDE = 1'b0,
        MODE_NORMAL   = 1'b1
    } boot_mode_e;

    typedef struct packed {
        logic phi2;
        logic rw;
        logic a15;
    } bus_sample_t;

    // A processor read: phase 2 active with read strobe high.
    function automatic logic is_cpu_read(input bus_sample_t s);
        return s.phi2 && s.rw;
    endfunction

    // Next stored mode; reset outranks the address set condition.
    function automatic boot_mode_e next_mode(input logic rst_i,
                                             input logic set_i,
                                             input boot_mode_e cur);
        if (rst_i)
            return MODE_OVERRIDE;
        else if (set_i)
            return MODE_NORMAL;
        else
            return cur;
    endfunction

endpackage

// File: rtl/bootovr_mode_reg.sv
module bootovr_mode_reg
    import bootovr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_req,
    output boot_mode_e mode_q,
    output boot_mode_e mode_eff
);
    boot_mode_e mode_r;

    always_ff @(posedge clk) begin
        mode_r <= next_mode(rst, set_req, mode_r);
    end

    // Effective mode reacts immediately, like an asynchronous latch,
    // but reset suppresses the set path.
    always_comb begin
        if (rst)
            mode_eff = MODE_OVERRIDE;
        else if (set_req)
            mode_eff = MODE_NORMAL;
        else
            mode_eff = mode_r;
    end

    assign mode_q = mode_r;
endmodule

// File: rtl/bootovr_read_det.sv
module bootovr_read_det
    import bootovr_pkg::*;
(
    input  bus_sample_t smp,
    output logic        read_hit
);
    assign read_hit = is_cpu_read(smp);
endmodule

// File: rtl/bootovr_en_sel.sv
module bootovr_en_sel
    import bootovr_pkg::*;
(
    input  boot_mode_e mode_eff,
    input  logic       read_hit,
    input  logic       addr_hi,
    output logic       en_n
);
    logic drive;

    always_comb begin
        unique case (mode_eff)
            MODE_OVERRIDE: drive = read_hit;
            MODE_NORMAL:   drive = addr_hi;
            default:       drive = 1'b0;
        endcase
    end

    assign en_n = ~drive;
endmodule

// File: rtl/bootovr_bus_enable.sv
module bootovr_bus_enable
    import bootovr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic phi2,
    input  logic rw,
    input  logic a15_gated,
    output logic buf_en_n
);
    bus_sample_t smp;
    boot_mode_e  mode_q;
    boot_mode_e  mode_eff;
    logic        read_hit;

    always_comb begin
        smp.phi2 = phi2;
        smp.rw   = rw;
        smp.a15  = a15_gated;
    end

    bootovr_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .set_req  (smp.a15),
        .mode_q   (mode_q),
        .mode_eff (mode_eff)
    );

    bootovr_read_det u_rd (
        .smp      (smp),
        .read_hit (read_hit)
    );

    bootovr_en_sel u_sel (
        .mode_eff (mode_eff),
        .read_hit (read_hit),
        .addr_hi  (smp.a15),
        .en_n     (buf_en_n)
    );
endmodule

// File: rtl/bootovr_bus_enable_chk.sv
module bootovr_bus_enable_chk
    import bootovr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       phi2,
    input logic       rw,
    input logic       a15_gated,
    input logic       buf_en_n,
    input boot_mode_e mode_q
);
    // R1 / R6: reset always leaves the stored mode in override
    assert_reset_override_R1: assert property (@(posedge clk)
        rst |=> (mode_q == MODE_OVERRIDE));

    // R2
    assert_override_read_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_OVERRIDE && !a15_gated && phi2 && rw) |-> !buf_en_n);

    // R3
    assert_override_noread_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_OVERRIDE && !a15_gated && !(phi2 && rw)) |-> buf_en_n);

    // R4: once normal, stays normal
    assert_sticky_normal_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_NORMAL) |=> (mode_q == MODE_NORMAL));

    // R4: a high address line outside reset latches normal mode
    assert_set_normal_R4: assert property (@(posedge clk) disable iff (rst)
        a15_gated |=> (mode_q == MODE_NORMAL));

    // R5
    assert_normal_decode_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_NORMAL) |-> (buf_en_n == !a15_gated));

    // R6: during reset a write never enables the buffer
    assert_reset_priority_R6: assert property (@(posedge clk)
        (rst && !rw) |-> buf_en_n);
endmodule

bind bootovr_bus_enable bootovr_bus_enable_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .phi2      (phi2),
    .rw        (rw),
    .a15_gated (a15_gated),
    .buf_en_n  (buf_en_n),
    .mode_q    (mode_q)
);

// File: tb/bootovr_bus_enable_tb_top.sv
module bootovr_bus_enable_tb_top;
    logic clk = 1'b0;
    logic rst, phi2, rw, a15_gated;
    logic buf_en_n;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bootovr_bus_enable dut_i (
        .clk       (clk),
        .rst       (rst),
        .phi2      (phi2),
        .rw        (rw),
        .a15_gated (a15_gated),
        .buf_en_n  (buf_en_n)
    );

    // {rst, phi2, rw, a15_gated, expected buf_en_n}
    localparam int NVEC = 19;
    localparam logic [4:0] VEC [NVEC] = '{
        5'b1_1_1_0_0,  // R1 read during reset, override
        5'b1_0_1_0_1,  // R1 idle during reset
        5'b0_1_1_0_0,  // R2 vector fetch low byte
        5'b0_1_1_0_0,  // R2 vector fetch high byte
        5'b0_1_1_0_0,  // R2 first opcode
        5'b0_0_1_0_1,  // R3 phi2 low
        5'b0_1_0_0_1,  // R3 control-port write, ROM off
        5'b0_0_0_0_1,  // R3 idle write phase
        5'b0_1_1_1_0,  // R4 address line rises, normal at once
        5'b0_1_1_0_1,  // R5 read, low half, disabled
        5'b0_1_0_1_0,  // R5 write, high half, enabled
        5'b0_0_0_1_0,  // R5 phi2 low, high half, enabled
        5'b0_0_1_0_1,  // R5 R7 idle low half
        5'b0_1_1_0_1,  // R4 sticky: read low half stays off
        5'b1_1_1_1_0,  // R6 reset + address high, read: override
        5'b1_0_0_1_1,  // R6 reset + address high, write: off
        5'b0_1_1_0_0,  // R6 back in override after reset
        5'b0_1_0_1_0,  // R4 write with address high: normal
        5'b0_1_1_0_1   // R4 stays normal
    };

    task automatic check(input logic exp, input string req);
        checks++;
        if (buf_en_n !== exp) begin
            errors++;
            $display("FAIL %s: buf_en_n=%b expected %b", req, buf_en_n, exp);
        end
    endtask

    task automatic drive(input logic r, input logic p, input logic w, input logic a);
        @(negedge clk);
        rst = r; phi2 = p; rw = w; a15_gated = a;
        #1;
    endtask

    initial begin
        rst = 1'b1; phi2 = 1'b0; rw = 1'b1; a15_gated = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(1'b1, "R1 reset idle");

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
            check(VEC[i][0], $sformatf("vector %0d", i));
        end

        // R1: address high throughout reset, release: still override
        drive(1'b1, 1'b0, 1'b1, 1'b1);
        drive(1'b1, 1'b0, 1'b1, 1'b1);
        drive(1'b0, 1'b0, 1'b1, 1'b0);
        check(1'b1, "R1 idle after release");
        drive(1'b0, 1'b1, 1'b1, 1'b0);
        check(1'b0, "R1 override read after release");

        // R4: single-cycle address pulse latches normal mode
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        check(1'b0, "R4 pulse enables");
        for (int k = 0; k < 5; k++) begin
            drive(1'b0, 1'b1, 1'b1, 1'b0);
            check(1'b1, "R4 read after pulse stays off");
        end
        drive(1'b0, 1'b1, 1'b0, 1'b1);
        check(1'b0, "R5 write high half");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: done=0 expected 1");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule